// File: doc/BRIEF.md
# Receive FIFO Idle Watchdog

This block watches one receiver's FIFO. When characters sit unread and nothing moves in or out of the FIFO for a programmed number of bit times, it raises a timeout flag and, if software has enabled it, an interrupt request. It catches the end of a message that leaves too few characters to cross the fill-level interrupt threshold, so the host still learns that data is waiting.

Time is measured in bit periods. The baud generator supplies a one-cycle `bit_tick` pulse. The count advances on that pulse only while the FIFO holds data. Any host read from the FIFO, and any character the receiver writes into it, restarts the count. A receiver reset also clears the timer. All pins are plain control and status levels or one-cycle strobes. No data passes through the block, so it has no valid/ready handshake.

Top module: `rx_idle_wdog`

## Requirements
- R1: After `rst_n` is released, `timeout` and `irq` are low.
- R2: With `fifo_nonempty` high and no restart, `timeout` goes high on the clock edge that samples the LIMIT-th `bit_tick` (LIMIT = 64 by default). Before that tick it stays low.
- R3: A `host_rd` strobe clears `timeout` on the next edge and restarts the count from zero.
- R4: An `rx_wr` strobe clears `timeout` on the next edge and restarts the count from zero, including in the middle of a count.
- R5: While `fifo_nonempty` is low, ticks are not counted and the count is held at zero. A later expiry needs a full LIMIT ticks.
- R6: Once set, `timeout` stays high through further ticks and through the FIFO going empty. The count saturates and does not wrap, until a restart or a receiver reset.
- R7: `irq` is high exactly when `timeout` is high and `wdog_en` is high. `wdog_en` has no effect on `timeout`.
- R8: When a restart strobe and `bit_tick` fall in the same cycle, the restart wins and that tick is not counted.
- R9: A `rx_rst` pulse clears `timeout` and the count on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rst | input | 1 | Synchronous receiver reset strobe |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| host_rd | input | 1 | Host read strobe on the receive FIFO |
| rx_wr | input | 1 | Receiver write strobe into the receive FIFO |
| wdog_en | input | 1 | Software interrupt enable for the watchdog |
| timeout | output | 1 | Latched expiry flag |
| irq | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
The collision that matters is a restart strobe (`host_rd` or `rx_wr`) in the same cycle as `bit_tick`, most critically on the tick that would otherwise expire the timer. The bench first brings the count to LIMIT-1 ticks. It then drives the tick and a host read together and requires `timeout` to stay low. Exactly LIMIT-1 further ticks must then leave it low, and one more tick must set it, which proves the colliding tick was dropped and the count started from zero.

// File: rtl/rx_idle_wdog_pkg.sv
package rx_idle_wdog_pkg;

  localparam int unsigned WDOG_LIMIT_DEFAULT = 64;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_rst,
  input  logic host_rd,
  input  logic rx_wr,
  input  logic bit_tick,
  input  logic fifo_nonempty,
  output logic clr,
  output logic hold,
  output logic step
);
  // Restart sources outrank the tick (R8)
  assign clr  = host_rd | rx_wr | rx_rst;
  assign hold = ~fifo_nonempty;
  assign step = bit_tick & fifo_nonempty & ~clr;

  a_r8_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || rx_wr) |-> !step);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned LIMIT = rx_idle_wdog_pkg::WDOG_LIMIT_DEFAULT,
  parameter int unsigned CW    = rx_idle_wdog_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          reach
);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  // Pulse on the tick that completes the window
  assign reach = step && (cnt == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr || hold)           cnt <= '0;
    else if (step && cnt != LIM_V)  cnt <= cnt + 1'b1;
  end

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt == '0);
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LIM_V && !clr && !hold) |=> cnt == LIM_V);
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_V);
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic reach,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (clr)   flag <= 1'b0;
    else if (reach) flag <= 1'b1;
  end

  a_r2_set_on_reach: assert property (@(posedge clk) disable iff (!rst_n)
    (reach && !clr) |=> flag);
  a_r3_clear_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/rx_idle_wdog.sv
module rx_idle_wdog #(
  parameter int unsigned LIMIT = rx_idle_wdog_pkg::WDOG_LIMIT_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_rst,
  input  logic bit_tick,
  input  logic fifo_nonempty,
  input  logic host_rd,
  input  logic rx_wr,
  input  logic wdog_en,
  output logic timeout,
  output logic irq
);
  localparam int unsigned CW = rx_idle_wdog_pkg::cnt_width(LIMIT);

  logic          clr, hold, step, reach;
  logic [CW-1:0] cnt;

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .host_rd(host_rd),
    .rx_wr(rx_wr), .bit_tick(bit_tick), .fifo_nonempty(fifo_nonempty),
    .clr(clr), .hold(hold), .step(step)
  );

  wdog_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold), .step(step),
    .cnt(cnt), .reach(reach)
  );

  wdog_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clr(clr), .reach(reach), .flag(timeout)
  );

  assign irq = timeout & wdog_en;

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en |-> !irq);
  a_r9_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!timeout && cnt == '0));
endmodule

// File: tb/test_rx_idle_wdog.sv
module test_rx_idle_wdog;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LIMIT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_rst = 0, bit_tick = 0, fifo_nonempty = 0;
  logic host_rd = 0, rx_wr = 0, wdog_en = 0;
  logic timeout, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_idle_wdog #(.LIMIT(LIMIT)) i_rx_idle_wdog (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .bit_tick(bit_tick),
    .fifo_nonempty(fifo_nonempty), .host_rd(host_rd), .rx_wr(rx_wr),
    .wdog_en(wdog_en), .timeout(timeout), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; @(negedge clk);
      bit_tick = 0; @(negedge clk);
    end
  endtask

  task automatic pulse_rxrst();
    rx_rst = 1; @(negedge clk); rx_rst = 0;
  endtask

  task automatic t_reset();
    chk("R1 timeout", timeout, 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_expire();
    fifo_nonempty = 1; wdog_en = 1;
    ticks(LIMIT - 1);
    chk("R2 before", timeout, 1'b0);
    ticks(1);
    chk("R2 expire", timeout, 1'b1);
    chk("R7 irq on", irq, 1'b1);
  endtask

  task automatic t_sticky();
    ticks(10);
    chk("R6 more ticks", timeout, 1'b1);
    fifo_nonempty = 0; idle(3);
    chk("R6 empty", timeout, 1'b1);
    fifo_nonempty = 1;
  endtask

  task automatic t_enable();
    wdog_en = 0; #1;
    chk("R7 irq masked", irq, 1'b0);
    chk("R7 flag kept", timeout, 1'b1);
    wdog_en = 1; #1;
    chk("R7 irq back", irq, 1'b1);
  endtask

  task automatic t_read();
    host_rd = 1; @(negedge clk); host_rd = 0;
    chk("R3 clear", timeout, 1'b0);
    ticks(LIMIT - 1);
    chk("R3 restart", timeout, 1'b0);
    ticks(1);
    chk("R3 re-expire", timeout, 1'b1);
  endtask

  task automatic t_write();
    rx_wr = 1; @(negedge clk); rx_wr = 0;
    chk("R4 clear", timeout, 1'b0);
    ticks(40);
    rx_wr = 1; @(negedge clk); rx_wr = 0;
    ticks(LIMIT - 1);
    chk("R4 mid restart", timeout, 1'b0);
    ticks(1);
    chk("R4 expire", timeout, 1'b1);
  endtask

  task automatic t_rxrst();
    pulse_rxrst();
    chk("R9 clear", timeout, 1'b0);
    chk("R9 irq", irq, 1'b0);
  endtask

  task automatic t_empty();
    pulse_rxrst();
    fifo_nonempty = 0;
    ticks(LIMIT + 20);
    chk("R5 empty", timeout, 1'b0);
    fifo_nonempty = 1;
    ticks(LIMIT - 1);
    chk("R5 from zero", timeout, 1'b0);
    ticks(1);
    chk("R5 expire", timeout, 1'b1);
  endtask

  task automatic t_collide();
    pulse_rxrst();
    ticks(LIMIT - 1);
    bit_tick = 1; host_rd = 1; @(negedge clk);
    bit_tick = 0; host_rd = 0; @(negedge clk);
    chk("R8 no expire", timeout, 1'b0);
    ticks(LIMIT - 1);
    chk("R8 tick dropped", timeout, 1'b0);
    ticks(1);
    chk("R8 expire", timeout, 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_expire();
    t_sticky();
    t_enable();
    t_read();
    t_write();
    t_rxrst();
    t_empty();
    t_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule